// File: doc/BRIEF.md
# CPU Stall Guard for Disk Data Transfers

This block holds the processor in a wait state while a disk controller gets a data byte ready during double-density transfers. Software turns the mechanism on with a wait-enable control bit. When the bit is set and the processor touches the controller's data port, the block asserts a wait to the processor from the next clock cycle. The wait ends as soon as the controller raises its data request or its interrupt request. The interrupt request marks the end of a transfer, so the last access never stalls.

A watchdog counter bounds the stall. If neither request arrives within `WD_CYCLES` clock cycles, the block drops the wait on its own. It also sets a sticky flag, so software can see that a transfer went wrong before dynamic memory lost its contents for lack of refresh. Software clears the flag with a one-cycle clear strobe. All pins are plain control and status levels or strobes. No data stream passes through the block, so it has no valid/ready interface and no back-pressure.

Top module: `cpu_stall_guard`

## Requirements
- R1: After reset `cpu_wait` is 0 and `wd_fired` is 0.
- R2: While `wait_en` is 0, a data-port access (`port_access` = 1) never raises `cpu_wait`.
- R3: With `wait_en` = 1, `drq` = 0, `intrq` = 0 and no wait in progress, a cycle with `port_access` = 1 makes `cpu_wait` 1 from the following cycle.
- R4: An access in a cycle where `drq` or `intrq` is already 1 raises no wait.
- R5: While `cpu_wait` is 1, a cycle with `drq` = 1 makes `cpu_wait` 0 in the next cycle, and `wd_fired` does not change.
- R6: While `cpu_wait` is 1, a cycle with `intrq` = 1 makes `cpu_wait` 0 in the next cycle, and `wd_fired` does not change.
- R7: A wait that gets no release stays high for exactly `WD_CYCLES` cycles. It falls in the same cycle that `wd_fired` becomes 1.
- R8: The watchdog count restarts at every new wait. A wait that follows a shorter, released wait still lasts a full `WD_CYCLES` cycles.
- R9: `wd_fired` stays 1 until a cycle with `wd_clear` = 1, and reads 0 from the next cycle. If the watchdog fires in the same cycle as a clear, the flag is set.
- R10: Clearing `wait_en` during a wait makes `cpu_wait` 0 in the next cycle, and `wd_fired` does not change.
- R11: A request that arrives in the final watchdog cycle releases the wait as a normal release, and `wd_fired` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wait_en | input | 1 | Wait-generation enable control bit |
| port_access | input | 1 | One-cycle strobe: processor accesses the controller data port |
| drq | input | 1 | Controller data request |
| intrq | input | 1 | Controller interrupt request (end of transfer) |
| wd_clear | input | 1 | One-cycle strobe that clears the watchdog flag |
| cpu_wait | output | 1 | Wait to the processor, active high |
| wd_fired | output | 1 | Sticky flag: a wait was ended by the watchdog |

## Verification
The hardest case to reach is a race on the final watchdog cycle. To reach it, the stimulus holds a wait quiet for exactly `WD_CYCLES`-1 cycles, counted from the access. On the next cycle it either raises `drq`, which must win without setting the flag, or pulses `wd_clear`, which must lose to the firing watchdog. The bench also releases one wait partway through and at once starts another, to show that the count restarts rather than carrying over.

// File: rtl/stall_guard_pkg.sv
package stall_guard_pkg;

  typedef enum logic {
    HS_IDLE = 1'b0,
    HS_HOLD = 1'b1
  } hold_state_t;

  typedef enum logic [1:0] {
    RL_NONE    = 2'd0,
    RL_REQUEST = 2'd1,
    RL_TIMEOUT = 2'd2,
    RL_DISABLE = 2'd3
  } release_t;

endpackage

// File: rtl/sg_timeout_counter.sv
module sg_timeout_counter #(
  parameter int LIMIT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic run,
  output logic expire
);
  localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt;

  assign expire = run && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n)              cnt <= '0;
    else if (restart)        cnt <= '0;
    else if (run && !expire) cnt <= cnt + 1'b1;
  end

  // R7
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST);

  // R8
  restart_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (cnt == '0));

endmodule

// File: rtl/sg_hold_fsm.sv
module sg_hold_fsm
  import stall_guard_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic wait_en,
  input  logic access,
  input  logic drq,
  input  logic intrq,
  input  logic expire,
  output logic hold,
  output logic restart,
  output logic run,
  output logic timeout_rel
);
  hold_state_t state, state_nx;
  release_t    why;

  logic start;
  assign start = (state == HS_IDLE) && wait_en && access && !drq && !intrq;

  always_comb begin
    why = RL_NONE;
    if (state == HS_HOLD) begin
      if (!wait_en)            why = RL_DISABLE;
      else if (drq || intrq)   why = RL_REQUEST;
      else if (expire)         why = RL_TIMEOUT;
    end
  end

  always_comb begin
    state_nx = state;
    if (start)               state_nx = HS_HOLD;
    else if (why != RL_NONE) state_nx = HS_IDLE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= HS_IDLE;
    else        state <= state_nx;
  end

  assign hold        = (state == HS_HOLD);
  assign restart     = start;
  assign run         = hold;
  assign timeout_rel = (why == RL_TIMEOUT);

  // R2
  no_wait_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wait_en && !hold) |=> !hold);

  // R5
  req_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && (drq || intrq)) |=> !hold);

  // R10
  disable_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && !wait_en) |=> !hold);

  // R4
  early_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold && (drq || intrq)) |=> !hold);

endmodule

// File: rtl/sg_sticky_flag.sv
module sg_sticky_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clear,
  output logic flag
);
  always_ff @(posedge clk) begin
    if (!rst_n)     flag <= 1'b0;
    else if (set)   flag <= 1'b1;
    else if (clear) flag <= 1'b0;
  end

  // R9
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set |=> flag);

  // R9
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clear && !set) |=> !flag);

endmodule

// File: rtl/cpu_stall_guard.sv
module cpu_stall_guard #(
  parameter int WD_CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wait_en,
  input  logic port_access,
  input  logic drq,
  input  logic intrq,
  input  logic wd_clear,
  output logic cpu_wait,
  output logic wd_fired
);
  logic restart, run, expire, timeout_rel;

  sg_timeout_counter #(.LIMIT(WD_CYCLES)) u_cnt (
    .clk(clk), .rst_n(rst_n), .restart(restart), .run(run), .expire(expire)
  );

  sg_hold_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .wait_en(wait_en), .access(port_access),
    .drq(drq), .intrq(intrq), .expire(expire), .hold(cpu_wait),
    .restart(restart), .run(run), .timeout_rel(timeout_rel)
  );

  sg_sticky_flag u_flag (
    .clk(clk), .rst_n(rst_n), .set(timeout_rel), .clear(wd_clear),
    .flag(wd_fired)
  );

  // R3
  wait_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wait_en && port_access && !drq && !intrq && !cpu_wait) |=> cpu_wait);

  // R7
  fire_with_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wd_fired) |-> $fell(cpu_wait));

  // R11
  req_no_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wait && (drq || intrq) && !wd_fired) |=> !wd_fired);

endmodule

// File: tb/tb_cpu_stall_guard.sv
module tb_cpu_stall_guard;
  localparam int WD = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wait_en = 1'b0, port_access = 1'b0, drq = 1'b0, intrq = 1'b0, wd_clear = 1'b0;
  logic cpu_wait, wd_fired;

  always #2.5ns clk = ~clk;

  cpu_stall_guard #(.WD_CYCLES(WD)) dut (
    .clk(clk), .rst_n(rst_n), .wait_en(wait_en), .port_access(port_access),
    .drq(drq), .intrq(intrq), .wd_clear(wd_clear),
    .cpu_wait(cpu_wait), .wd_fired(wd_fired)
  );

  typedef struct {
    logic  w;
    logic  f;
    string tag;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int errors = 0;
  bit done = 0;

  // requirement-level model state
  logic m_wait = 1'b0;
  int   m_cnt = 0;
  logic m_fired = 1'b0;

  task automatic step(input logic en, input logic acc, input logic d,
                      input logic i, input logic clr, input string tag);
    logic fire;
    exp_t e;
    @(negedge clk);
    wait_en = en; port_access = acc; drq = d; intrq = i; wd_clear = clr;
    fire = 1'b0;
    if (m_wait) begin
      if (!en || d || i) m_wait = 1'b0;
      else if (m_cnt == WD - 1) begin m_wait = 1'b0; fire = 1'b1; end
      else m_cnt++;
    end else if (en && acc && !d && !i) begin
      m_wait = 1'b1; m_cnt = 0;
    end
    if (fire) m_fired = 1'b1;
    else if (clr) m_fired = 1'b0;
    e.w = m_wait; e.f = m_fired; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic quiet(input int n, input logic en, input string tag);
    for (int k = 0; k < n; k++) step(en, 0, 0, 0, 0, tag);
  endtask

  // monitor: compares after each edge
  initial begin
    exp_t e;
    forever begin
      @(posedge clk);
      #1ns;
      if (q.size() > 0) begin
        e = q.pop_front();
        checks++;
        if (cpu_wait !== e.w || wd_fired !== e.f) begin
          errors++;
          $display("FAIL %s: wait=%b fired=%b expected wait=%b fired=%b",
                   e.tag, cpu_wait, wd_fired, e.w, e.f);
        end
      end
    end
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 20000) begin @(posedge clk); cyc++; end
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1ns;
    checks++;
    if (cpu_wait !== 1'b0 || wd_fired !== 1'b0) begin
      errors++;
      $display("FAIL R1: wait=%b fired=%b expected 0 0", cpu_wait, wd_fired);
    end
    // R2: disabled accesses
    step(0, 1, 0, 0, 0, "R2"); quiet(2, 0, "R2"); step(0, 1, 0, 0, 0, "R2"); quiet(1, 0, "R2");
    // R3 + R5: wait, then data request
    step(1, 1, 0, 0, 0, "R3"); quiet(3, 1, "R3");
    step(1, 1, 0, 0, 0, "R3"); // access during hold ignored
    step(1, 0, 1, 0, 0, "R5"); quiet(2, 1, "R5");
    // R4: request already up
    step(1, 1, 1, 0, 0, "R4"); step(1, 0, 0, 0, 0, "R4");
    step(1, 1, 0, 1, 0, "R4"); step(1, 0, 0, 0, 0, "R4");
    // R6: interrupt release
    step(1, 1, 0, 0, 0, "R6"); quiet(2, 1, "R6"); step(1, 0, 0, 1, 0, "R6"); quiet(1, 1, "R6");
    // R7: timeout
    step(1, 1, 0, 0, 0, "R7"); quiet(WD + 2, 1, "R7");
    // R9: sticky then clear
    quiet(3, 1, "R9"); step(1, 0, 0, 0, 1, "R9"); quiet(1, 1, "R9");
    // R8: partial wait then full wait
    step(1, 1, 0, 0, 0, "R8"); quiet(5, 1, "R8"); step(1, 0, 1, 0, 0, "R8");
    step(1, 1, 0, 0, 0, "R8"); quiet(WD + 1, 1, "R8");
    step(1, 0, 0, 0, 1, "R8"); quiet(1, 1, "R8");
    // R11: request on final watchdog cycle
    step(1, 1, 0, 0, 0, "R11"); quiet(WD - 1, 1, "R11");
    step(1, 0, 1, 0, 0, "R11"); quiet(2, 1, "R11");
    // R9: fire and clear in same cycle
    step(1, 1, 0, 0, 0, "R9"); quiet(WD - 1, 1, "R9");
    step(1, 0, 0, 0, 1, "R9"); quiet(2, 1, "R9");
    step(1, 0, 0, 0, 1, "R9");
    // R10: enable dropped during wait
    step(1, 1, 0, 0, 0, "R10"); quiet(2, 1, "R10"); step(0, 0, 0, 0, 0, "R10"); quiet(2, 0, "R10");
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule